// File: doc/BRIEF.md
# SDRAM Initialization Command Trigger

This block holds the control fields of one SDRAM region and turns ordinary CPU bus accesses into one-shot SDRAM initialization commands. Software writes a configuration word that can arm a precharge-all request, a load-mode request, or both. The next qualifying access to the region becomes the matching SDRAM command instead of a normal transfer. The block drops the request bit itself when that command ends.

For a load-mode command the mode word comes from the low bits of the triggering access address, so software encodes the mode value in the address it touches. The data bus plays no part. A 3-bit mux code picks which bus address bit serves as the SDRAM command bit, and the bank-select bits sit just above it. A 2-bit port-size field sets the region's data width, and the block reports that width as a byte count.

Each access is held on the bus until a one-cycle acknowledge. A normal access produces one cycle of the NORMAL command. A triggered command is presented for `CMD_CYCLES` cycles, and the acknowledge follows.

Top module: `sdram_cmd_trigger`

## Requirements
- R1: After reset both request bits read 0, `busAck` and `sdCmdValid` are 0, the mux code is 0 and the port size is 32 bits (`portBytes` = 4).
- R2: An access with no qualifying request gives exactly one cycle of `sdCmdValid` with `sdCmd` = 0 (NORMAL). `busAck` follows in the next cycle.
- R3: When the precharge request is set, the next write whose width fits the port produces `sdCmd` = 1 (PALL) for `CMD_CYCLES` cycles. The precharge request bit clears in the same cycle that `busAck` rises.
- R4: A read does not trigger PALL, and neither does a write wider than the configured port. Either access passes as NORMAL and leaves the precharge request set. Width order: 8 < 16 < 32.
- R5: When the load-mode request is set and no precharge is pending, the next read or write produces `sdCmd` = 2 (MRS) for `CMD_CYCLES` cycles, and `sdAddr` equals `busAddr[SD_ADDR_W-1:0]`. The load-mode request bit clears when `busAck` rises.
- R6: With both requests set, a read passes as NORMAL. The next fitting write issues PALL and leaves the load-mode request set. The access after that issues MRS.
- R7: With mux code c (0..7), `sdCmdBit` = `busAddr[17+c]` and `sdBank` = `busAddr[18+c +: BANK_W]` of the access being served.
- R8: Port-size and access-size encoding: 00 = 32-bit, 01 = 8-bit, 10 or 11 = 16-bit. `portBytes` reports 4, 1 or 2 to match.
- R9: `busAck` lasts exactly one cycle and is never high together with `sdCmdValid`. `sdCmd` stays stable while `sdCmdValid` is high.
- R10: A configuration write with a request field at 0 cancels that pending request, and the next access is NORMAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgMux | input | 3 | Command/bank mux code |
| cfgPortSize | input | 2 | Port size (00=32, 01=8, 1x=16) |
| cfgPallReq | input | 1 | Precharge-all request value written |
| cfgMrsReq | input | 1 | Load-mode request value written |
| pallPending | output | 1 | Precharge-all request bit |
| mrsPending | output | 1 | Load-mode request bit |
| portBytes | output | 3 | Configured port width in bytes |
| busReq | input | 1 | Access request, held until `busAck` |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Access address |
| busSize | input | 2 | Access width, same encoding as port size |
| busAck | output | 1 | One-cycle access acknowledge |
| sdCmdValid | output | 1 | SDRAM command being presented |
| sdCmd | output | 2 | 0 NORMAL, 1 PALL, 2 MRS |
| sdAddr | output | SD_ADDR_W | SDRAM address pins (mode word during MRS) |
| sdBank | output | BANK_W | Bank-select bits |
| sdCmdBit | output | 1 | Selected command address bit |

## Verification
The checker watches the cycle-level handshake on every clock: the acknowledge is a single pulse and never overlaps a command, the command code holds steady while valid, PALL appears only on a write with the precharge request still set, and a request bit drops only together with the acknowledge. The ordering of commands, the mode word taken from the address, the bit positions chosen by each mux code, the width rule and cancellation by software depend on what was configured beforehand. Only the directed scenarios show those, by comparing against values worked out from the requirements.

// File: rtl/sdram_trig_pkg.sv
package sdram_trig_pkg;

  typedef enum logic [1:0] {
    CMD_NORMAL = 2'd0,
    CMD_PALL   = 2'd1,
    CMD_MRS    = 2'd2
  } sdCmd_e;

  typedef struct packed {
    logic capture;
    logic clrPall;
    logic clrMrs;
  } ctrlStrobe_t;

  function automatic logic [2:0] sizeBytes(input logic [1:0] sz);
    case (sz)
      2'b00:   sizeBytes = 3'd4;
      2'b01:   sizeBytes = 3'd1;
      default: sizeBytes = 3'd2;
    endcase
  endfunction

endpackage

// File: rtl/sdram_trig_datapath.sv
module sdram_trig_datapath
  import sdram_trig_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SD_ADDR_W = 13,
  parameter int BANK_W    = 2,
  parameter int CMD_BASE  = 17
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [2:0]           cfgMux,
  input  logic [1:0]           cfgPortSize,
  input  logic                 cfgPallReq,
  input  logic                 cfgMrsReq,
  input  logic [ADDR_W-1:0]    busAddr,
  input  ctrlStrobe_t          strobe,
  output logic                 pallPend,
  output logic                 mrsPend,
  output logic [1:0]           portSize,
  output logic [2:0]           portBytes,
  output logic [SD_ADDR_W-1:0] sdAddr,
  output logic [BANK_W-1:0]    sdBank,
  output logic                 sdCmdBit
);

  localparam int IDX_W = $clog2(ADDR_W);

  logic [2:0]        muxCode;
  logic [ADDR_W-1:0] capAddr;
  logic [ADDR_W-1:0] bankShift;
  logic [IDX_W-1:0]  cmdIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      muxCode  <= '0;
      portSize <= 2'b00;
      pallPend <= 1'b0;
      mrsPend  <= 1'b0;
    end else if (cfgWe) begin
      muxCode  <= cfgMux;
      portSize <= cfgPortSize;
      pallPend <= cfgPallReq;
      mrsPend  <= cfgMrsReq;
    end else begin
      if (strobe.clrPall) pallPend <= 1'b0;
      if (strobe.clrMrs)  mrsPend  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               capAddr <= '0;
    else if (strobe.capture) capAddr <= busAddr;
  end

  always_comb begin
    cmdIdx    = IDX_W'(CMD_BASE) + IDX_W'(muxCode);
    bankShift = capAddr >> (cmdIdx + IDX_W'(1));
    sdCmdBit  = capAddr[cmdIdx];
    sdBank    = bankShift[BANK_W-1:0];
    sdAddr    = capAddr[SD_ADDR_W-1:0];
    portBytes = sizeBytes(portSize);
  end

endmodule

// File: rtl/sdram_trig_ctrl.sv
module sdram_trig_ctrl
  import sdram_trig_pkg::*;
#(
  parameter int CMD_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busReq,
  input  logic        busWrite,
  input  logic [1:0]  busSize,
  input  logic        pallPend,
  input  logic        mrsPend,
  input  logic [1:0]  portSize,
  output ctrlStrobe_t strobe,
  output logic        busAck,
  output logic        sdCmdValid,
  output sdCmd_e      sdCmd
);

  localparam int CNT_W = $clog2(CMD_CYCLES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_ACK} state_e;

  state_e         state;
  sdCmd_e         curCmd, nextCmd;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmdLen;
  logic           widthOk;
  logic           lastCycle;

  always_comb begin
    widthOk = sizeBytes(busSize) <= sizeBytes(portSize);
    if (pallPend && busWrite && widthOk)  nextCmd = CMD_PALL;
    else if (mrsPend && !pallPend)        nextCmd = CMD_MRS;
    else                                  nextCmd = CMD_NORMAL;
    cmdLen    = (curCmd == CMD_NORMAL) ? CNT_W'(1) : CNT_W'(CMD_CYCLES);
    lastCycle = (state == ST_CMD) && (cnt == cmdLen - CNT_W'(1));
    strobe.capture = (state == ST_IDLE) && busReq;
    strobe.clrPall = lastCycle && (curCmd == CMD_PALL);
    strobe.clrMrs  = lastCycle && (curCmd == CMD_MRS);
    busAck     = (state == ST_ACK);
    sdCmdValid = (state == ST_CMD);
    sdCmd      = curCmd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      curCmd <= CMD_NORMAL;
      cnt    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (busReq) begin
          state  <= ST_CMD;
          curCmd <= nextCmd;
          cnt    <= '0;
        end
        ST_CMD: begin
          if (lastCycle) state <= ST_ACK;
          else           cnt   <= cnt + CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sdram_cmd_trigger.sv
module sdram_cmd_trigger
  import sdram_trig_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SD_ADDR_W  = 13,
  parameter int BANK_W     = 2,
  parameter int CMD_CYCLES = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [2:0]           cfgMux,
  input  logic [1:0]           cfgPortSize,
  input  logic                 cfgPallReq,
  input  logic                 cfgMrsReq,
  output logic                 pallPending,
  output logic                 mrsPending,
  output logic [2:0]           portBytes,
  input  logic                 busReq,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [1:0]           busSize,
  output logic                 busAck,
  output logic                 sdCmdValid,
  output logic [1:0]           sdCmd,
  output logic [SD_ADDR_W-1:0] sdAddr,
  output logic [BANK_W-1:0]    sdBank,
  output logic                 sdCmdBit
);

  ctrlStrobe_t strobe;
  logic [1:0]  portSize;
  sdCmd_e      cmdEnum;

  sdram_trig_datapath #(
    .ADDR_W(ADDR_W), .SD_ADDR_W(SD_ADDR_W), .BANK_W(BANK_W), .CMD_BASE(17)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMux(cfgMux),
    .cfgPortSize(cfgPortSize), .cfgPallReq(cfgPallReq), .cfgMrsReq(cfgMrsReq),
    .busAddr(busAddr), .strobe(strobe), .pallPend(pallPending),
    .mrsPend(mrsPending), .portSize(portSize), .portBytes(portBytes),
    .sdAddr(sdAddr), .sdBank(sdBank), .sdCmdBit(sdCmdBit)
  );

  sdram_trig_ctrl #(.CMD_CYCLES(CMD_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
    .busSize(busSize), .pallPend(pallPending), .mrsPend(mrsPending),
    .portSize(portSize), .strobe(strobe), .busAck(busAck),
    .sdCmdValid(sdCmdValid), .sdCmd(cmdEnum)
  );

  assign sdCmd = cmdEnum;

endmodule

// File: rtl/sdram_cmd_trigger_chk.sv
module sdram_cmd_trigger_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWe,
  input logic       busWrite,
  input logic       busAck,
  input logic       sdCmdValid,
  input logic [1:0] sdCmd,
  input logic       pallPending,
  input logic       mrsPending
);

  // R9
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !busAck);

  // R9
  ack_cmd_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busAck && sdCmdValid));

  // R9
  cmd_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdCmdValid && $past(sdCmdValid)) |-> $stable(sdCmd));

  // R3
  pall_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdCmdValid && sdCmd == 2'd1) |-> (busWrite && pallPending));

  // R3
  pall_clear_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pallPending) && !$past(cfgWe)) |-> busAck);

  // R5
  mrs_clear_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(mrsPending) && !$past(cfgWe)) |-> busAck);

  // R5
  mrs_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdCmdValid && sdCmd == 2'd2) |-> mrsPending);

endmodule

bind sdram_cmd_trigger sdram_cmd_trigger_chk u_chk (.*);

// File: tb/sdram_cmd_trigger_tb.sv
module sdram_cmd_trigger_tb;

  localparam int ADDR_W = 32, SD_ADDR_W = 13, BANK_W = 2, CMD_CYCLES = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWe = 0, cfgPallReq = 0, cfgMrsReq = 0;
  logic [2:0] cfgMux = 0;
  logic [1:0] cfgPortSize = 0;
  logic pallPending, mrsPending;
  logic [2:0] portBytes;
  logic busReq = 0, busWrite = 0;
  logic [ADDR_W-1:0] busAddr = 0;
  logic [1:0] busSize = 0;
  logic busAck, sdCmdValid, sdCmdBit;
  logic [1:0] sdCmd;
  logic [SD_ADDR_W-1:0] sdAddr;
  logic [BANK_W-1:0] sdBank;

  int nChecks = 0, nFails = 0;
  int obsCmd, obsLen, obsAddr, obsBank, obsBit;

  always #2 clk = ~clk;

  sdram_cmd_trigger #(.ADDR_W(ADDR_W), .SD_ADDR_W(SD_ADDR_W), .BANK_W(BANK_W),
    .CMD_CYCLES(CMD_CYCLES)) u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] mux, input logic [1:0] ps,
                          input logic pall, input logic mrs);
    @(negedge clk);
    cfgWe = 1; cfgMux = mux; cfgPortSize = ps; cfgPallReq = pall; cfgMrsReq = mrs;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic access(input logic wr, input logic [ADDR_W-1:0] addr,
                        input logic [1:0] sz);
    @(negedge clk);
    busReq = 1; busWrite = wr; busAddr = addr; busSize = sz;
    obsLen = 0; obsCmd = -1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sdCmdValid) begin
        obsLen++; obsCmd = sdCmd; obsAddr = sdAddr; obsBank = sdBank; obsBit = sdCmdBit;
      end
      if (busAck) break;
    end
    busReq = 0;
  endtask

  task automatic testReset();
    check(pallPending == 0 && mrsPending == 0, "R1 pending", pallPending + mrsPending, 0);
    check(busAck == 0 && sdCmdValid == 0, "R1 idle", busAck + sdCmdValid, 0);
    check(portBytes == 4, "R1 portBytes", portBytes, 4);
  endtask

  task automatic testNormal();
    access(0, 32'h0000_0123, 2'b00);
    check(obsCmd == 0, "R2 cmd", obsCmd, 0);
    check(obsLen == 1, "R2 length", obsLen, 1);
  endtask

  task automatic testPortWidth();
    cfgWrite(0, 2'b01, 0, 0); check(portBytes == 1, "R8 ps01", portBytes, 1);
    cfgWrite(0, 2'b10, 0, 0); check(portBytes == 2, "R8 ps10", portBytes, 2);
    cfgWrite(0, 2'b11, 0, 0); check(portBytes == 2, "R8 ps11", portBytes, 2);
    cfgWrite(0, 2'b00, 0, 0); check(portBytes == 4, "R8 ps00", portBytes, 4);
  endtask

  task automatic testPall();
    cfgWrite(0, 2'b00, 1, 0);
    access(0, 32'h40, 2'b00);
    check(obsCmd == 0, "R4 read no pall", obsCmd, 0);
    check(pallPending == 1, "R4 still pending", pallPending, 1);
    access(1, 32'h40, 2'b00);
    check(obsCmd == 1, "R3 pall cmd", obsCmd, 1);
    check(obsLen == CMD_CYCLES, "R3 pall length", obsLen, CMD_CYCLES);
    check(pallPending == 0, "R3 self clear", pallPending, 0);
  endtask

  task automatic testPallWidth();
    cfgWrite(0, 2'b01, 1, 0);
    access(1, 32'h80, 2'b10);
    check(obsCmd == 0, "R4 too wide", obsCmd, 0);
    check(pallPending == 1, "R4 wide keeps pending", pallPending, 1);
    access(1, 32'h80, 2'b01);
    check(obsCmd == 1, "R3 byte pall", obsCmd, 1);
    check(pallPending == 0, "R3 byte clear", pallPending, 0);
  endtask

  task automatic testMrs();
    cfgWrite(0, 2'b00, 0, 1);
    access(0, 32'h0000_0033, 2'b00);
    check(obsCmd == 2, "R5 mrs cmd", obsCmd, 2);
    check(obsLen == CMD_CYCLES, "R5 mrs length", obsLen, CMD_CYCLES);
    check(obsAddr == 32'h33, "R5 mode word", obsAddr, 32'h33);
    check(mrsPending == 0, "R5 self clear", mrsPending, 0);
    cfgWrite(0, 2'b00, 0, 1);
    access(1, 32'h0000_1A5A, 2'b00);
    check(obsCmd == 2 && obsAddr == 32'h1A5A, "R5 write mrs", obsAddr, 32'h1A5A);
  endtask

  task automatic testBoth();
    cfgWrite(0, 2'b00, 1, 1);
    access(0, 32'h10, 2'b00);
    check(obsCmd == 0, "R6 read normal", obsCmd, 0);
    access(1, 32'h10, 2'b00);
    check(obsCmd == 1, "R6 pall first", obsCmd, 1);
    check(mrsPending == 1 && pallPending == 0, "R6 mrs kept", mrsPending, 1);
    access(0, 32'h22, 2'b00);
    check(obsCmd == 2, "R6 mrs second", obsCmd, 2);
    check(mrsPending == 0, "R6 mrs cleared", mrsPending, 0);
  endtask

  task automatic testMux();
    for (int c = 0; c < 8; c++) begin
      cfgWrite(c[2:0], 2'b00, 0, 0);
      access(0, (32'd1 << (17 + c)) | (32'(c % 4) << (18 + c)), 2'b00);
      check(obsBit == 1, $sformatf("R7 cmd bit c=%0d", c), obsBit, 1);
      check(obsBank == c % 4, $sformatf("R7 bank c=%0d", c), obsBank, c % 4);
      access(0, (32'd1 << (16 + c)) | (32'd3 << (19 + c)), 2'b00);
      check(obsBit == 0, $sformatf("R7 low bit c=%0d", c), obsBit, 0);
      check(obsBank == 2, $sformatf("R7 bank hi c=%0d", c), obsBank, 2);
    end
  endtask

  task automatic testCancel();
    cfgWrite(0, 2'b00, 1, 1);
    cfgWrite(0, 2'b00, 0, 0);
    check(pallPending == 0 && mrsPending == 0, "R10 cancel", pallPending + mrsPending, 0);
    access(1, 32'h4, 2'b00);
    check(obsCmd == 0, "R10 normal after cancel", obsCmd, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1;
        @(negedge clk);
        testReset();
        testNormal();
        testPortWidth();
        testPall();
        testPallWidth();
        testMrs();
        testBoth();
        testMux();
        testCancel();
      end
      begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule